// File: doc/BRIEF.md
# Iterative Circular CORDIC Engine

This block evaluates trigonometric quantities with the circular CORDIC recurrence. It keeps signed fixed-point x, y and z working registers and applies one shift-and-add micro-rotation per clock. A single shared datapath serves every step. The shift amount and the elementary angle both come from the step counter, and the angle for step i is atan(2^-i), taken from a constant table that is computed at elaboration.

In rotation mode the engine steers z toward zero. Starting from (x, 0, θ), it returns a scaled cosine and sine of θ in x and y. In vectoring mode it steers y toward zero. It returns the scaled magnitude of (x, y) in x and the accumulated angle in z.

The engine applies no gain correction. Every result in x and y carries the circular gain of about 1.6467602581. A caller that needs unscaled results pre-multiplies its inputs by about 0.6072529350. Angles are coded so that π equals 2^13. A request is accepted only while the engine is idle, and completion is signalled by a one-cycle `done` pulse.

Top module: `cordic_iter_engine`

## Requirements
- R1: In rotation mode (`mode`=0), after 14 steps the outputs equal the exact 16-bit two's complement recurrence. Each step computes x' = x − d·(y>>>i), y' = y + d·(x>>>i) and z' = z − d·A[i], where d ∈ {+1, −1} and i runs from 0 to 13.
- R2: In vectoring mode (`mode`=1), the outputs equal the same 14-step recurrence.
- R3: In rotation mode d is +1 when z ≥ 0 (z = 0 included) and −1 when z < 0.
- R4: In vectoring mode d is +1 when y < 0 and −1 when y ≥ 0 (y = 0 included).
- R5: The shift by i is arithmetic, so negative x and y keep their sign when shifted.
- R6: The angle table entry A[i] is atan(2^-i)·2^13/π rounded to the nearest integer, so A[0] = 2048.
- R7: `done` is high for exactly one cycle, sampled N+1 rising edges after the edge that sees `start` (N = 14), and the results are valid in that cycle.
- R8: A `start` seen while a computation is running is ignored. It produces no extra `done` and does not alter the running result.
- R9: `x_out`, `y_out` and `z_out` hold their value from `done` until the next accepted computation completes.
- R10: After reset, `done` is 0 and all three outputs are 0.
- R11: The magnitude in x and y grows by the circular gain. Rotating (9950, 0, π/4) gives x and y within 8 LSB of 16384·cos(π/4), and vectoring (12000, 9000) gives x within 8 LSB of 1.64676·15000 and z within 8 LSB of atan2(9000, 12000)·2^13/π.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation when idle |
| mode | input | 1 | 0 = rotation, 1 = vectoring; captured with start |
| x_in | input | 16 | Initial x, two's complement |
| y_in | input | 16 | Initial y, two's complement |
| z_in | input | 16 | Initial angle, π = 2^13 |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Final x |
| y_out | output | 16 | Final y |
| z_out | output | 16 | Final z |

## Verification
Any internal fault in this block is exposed at the ports within a single computation. A wrong table entry, a logical instead of arithmetic shift, or a flipped tie rule at z = 0 or y = 0 changes the final x, y or z by at least one LSB. These outputs are compared bit-exactly against an independent step model when `done` rises, 15 cycles after the request. A counter or control fault instead shows up as `done` arriving on the wrong cycle, an extra pulse, or outputs that move between completions. Each of these is caught in the cycle it occurs.

// File: rtl/cordic_iter_pkg.sv
package cordic_iter_pkg;

   typedef enum logic {
      CM_ROTATE = 1'b0,
      CM_VECTOR = 1'b1
   } cordic_mode_e;

   // Angle code of atan(2^-idx) with pi scaled to 2^pi_log2.
   // The series sum_n (-1)^n t^(2n+1)/(2n+1) is evaluated in Q32, with t a power of two.
   function automatic longint atan_code(input int idx, input int pi_log2);
      longint acc;
      longint term;
      int     sh;
      acc = 0;
      if (idx == 0) begin
         return longint'(1) <<< (pi_log2 - 2);
      end
      for (int n = 0; n < 32; n++) begin
         sh = 32 - idx * (2 * n + 1);
         if (sh >= 0) begin
            term = (longint'(1) <<< sh) / longint'(2 * n + 1);
            if ((n % 2) == 1) acc = acc - term;
            else              acc = acc + term;
         end
      end
      // multiply by 1/pi in Q30, then rescale to the angle code with rounding
      return (acc * 64'sd341782638 + (longint'(1) <<< (61 - pi_log2))) >>> (62 - pi_log2);
   endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom #(
   parameter int STEPS   = 14,
   parameter int ZW      = 16,
   parameter int PI_LOG2 = 13,
   localparam int IW     = (STEPS > 1) ? $clog2(STEPS) : 1,
   localparam int DEPTH  = 1 << IW
) (
   input  logic [IW-1:0]        idx,
   output logic signed [ZW-1:0] angle
);
   import cordic_iter_pkg::*;

   logic signed [ZW-1:0] tbl [DEPTH];

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      if (g < STEPS) begin : g_used
         assign tbl[g] = ZW'(atan_code(g, PI_LOG2));
      end else begin : g_pad
         assign tbl[g] = '0;
      end
   end

   assign angle = tbl[idx];
endmodule

// File: rtl/cordic_micro_rot.sv
module cordic_micro_rot #(
   parameter int W  = 16,
   parameter int ZW = 16,
   parameter int SW = 4
) (
   input  logic                 vec_mode,
   input  logic [SW-1:0]        sh,
   input  logic signed [W-1:0]  x,
   input  logic signed [W-1:0]  y,
   input  logic signed [ZW-1:0] z,
   input  logic signed [ZW-1:0] ang,
   output logic signed [W-1:0]  x_nx,
   output logic signed [W-1:0]  y_nx,
   output logic signed [ZW-1:0] z_nx
);
   logic                dir_pos;
   logic signed [W-1:0] x_sh;
   logic signed [W-1:0] y_sh;

   always_comb begin
      // rotation follows the sign of z, vectoring opposes the sign of y
      dir_pos = vec_mode ? y[W-1] : ~z[ZW-1];
      x_sh    = x >>> sh;
      y_sh    = y >>> sh;
      if (dir_pos) begin
         x_nx = x - y_sh;
         y_nx = y + x_sh;
         z_nx = z - ang;
      end else begin
         x_nx = x + y_sh;
         y_nx = y - x_sh;
         z_nx = z + ang;
      end
   end
endmodule

// File: rtl/cordic_step_ctrl.sv
module cordic_step_ctrl #(
   parameter int STEPS = 14,
   localparam int IW   = (STEPS > 1) ? $clog2(STEPS) : 1,
   localparam logic [IW-1:0] LAST = IW'(STEPS - 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          accept,
   output logic          busy,
   output logic          finish,
   output logic [IW-1:0] idx,
   output logic          done
);
   assign accept = start & ~busy;
   assign finish = busy & (idx == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         idx  <= '0;
         done <= 1'b0;
      end else begin
         done <= finish;
         if (accept) begin
            busy <= 1'b1;
            idx  <= '0;
         end else if (finish) begin
            busy <= 1'b0;
            idx  <= '0;
         end else if (busy) begin
            idx <= idx + 1'b1;
         end
      end
   end

   // R8: a request during a run neither restarts nor stalls the step count
   assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && idx != LAST) |=> (busy && idx == $past(idx) + 1'b1));

   // R7: completion pulse lasts a single cycle
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/cordic_iter_engine.sv
module cordic_iter_engine #(
   parameter int W       = 16,
   parameter int ZW      = 16,
   parameter int STEPS   = 14,
   parameter int PI_LOG2 = 13,
   localparam int IW     = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          mode,
   input  logic [W-1:0]  x_in,
   input  logic [W-1:0]  y_in,
   input  logic [ZW-1:0] z_in,
   output logic          done,
   output logic [W-1:0]  x_out,
   output logic [W-1:0]  y_out,
   output logic [ZW-1:0] z_out
);
   import cordic_iter_pkg::*;

   if (STEPS < 1 || STEPS > W) begin : g_bad_steps
      $error("cordic_iter_engine: STEPS must lie in 1..W");
   end
   if (PI_LOG2 < 2 || PI_LOG2 > ZW - 2) begin : g_bad_scale
      $error("cordic_iter_engine: PI_LOG2 must lie in 2..ZW-2");
   end

   logic                 accept, busy, finish;
   logic [IW-1:0]        idx;
   cordic_mode_e         mode_r;
   logic signed [W-1:0]  x_r, y_r, x_nx, y_nx;
   logic signed [ZW-1:0] z_r, z_nx, angle;
   logic signed [W-1:0]  x_o, y_o;
   logic signed [ZW-1:0] z_o;

   cordic_step_ctrl #(.STEPS(STEPS)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .accept (accept),
      .busy   (busy),
      .finish (finish),
      .idx    (idx),
      .done   (done)
   );

   cordic_atan_rom #(.STEPS(STEPS), .ZW(ZW), .PI_LOG2(PI_LOG2)) u_rom (
      .idx   (idx),
      .angle (angle)
   );

   cordic_micro_rot #(.W(W), .ZW(ZW), .SW(IW)) u_rot (
      .vec_mode (mode_r == CM_VECTOR),
      .sh       (idx),
      .x        (x_r),
      .y        (y_r),
      .z        (z_r),
      .ang      (angle),
      .x_nx     (x_nx),
      .y_nx     (y_nx),
      .z_nx     (z_nx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_r <= CM_ROTATE;
         x_r    <= '0;
         y_r    <= '0;
         z_r    <= '0;
         x_o    <= '0;
         y_o    <= '0;
         z_o    <= '0;
      end else begin
         if (accept) begin
            mode_r <= cordic_mode_e'(mode);
            x_r    <= signed'(x_in);
            y_r    <= signed'(y_in);
            z_r    <= signed'(z_in);
         end else if (busy) begin
            x_r <= x_nx;
            y_r <= y_nx;
            z_r <= z_nx;
         end
         if (finish) begin
            x_o <= x_nx;
            y_o <= y_nx;
            z_o <= z_nx;
         end
      end
   end

   assign x_out = x_o;
   assign y_out = y_o;
   assign z_out = z_o;

   // R3: rotation with non-negative z subtracts the table angle
   assert_rot_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_r == CM_ROTATE && !z_r[ZW-1]) |=> (z_r == $past(z_r) - $past(angle)));

   // R4: vectoring with non-negative y adds the table angle
   assert_vec_dir_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && mode_r == CM_VECTOR && !y_r[W-1]) |=> (z_r == $past(z_r) + $past(angle)));

   // R9: results move only in the cycle that reports completion
   assert_hold_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable({x_o, y_o, z_o}));

   // R6: the first table entry is a quarter of pi
   assert_first_angle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && idx == '0) |-> (angle == ZW'(1 << (PI_LOG2 - 2))));
endmodule

// File: tb/test_cordic_iter_engine.sv
module test_cordic_iter_engine;
   localparam int CLK_PERIOD = 10;
   localparam int N = 14;
   localparam real PI = 3.141592653589793;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode = 1'b0;
   logic [15:0] x_in = '0, y_in = '0, z_in = '0;
   logic        done;
   logic [15:0] x_out, y_out, z_out;

   cordic_iter_engine i_cordic_iter_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .x_in(x_in), .y_in(y_in), .z_in(z_in),
      .done(done), .x_out(x_out), .y_out(y_out), .z_out(z_out)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0, n_done = 0;
   int tbl [N];
   int q_x[$], q_y[$], q_z[$], q_c[$];
   string q_t[$];
   int last_x, last_y, last_z;
   bit finished = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   task automatic model(input bit m, input int xi, input int yi, input int zi,
                        output int xo, output int yo, output int zo);
      logic signed [15:0] x, y, z, xs, ys;
      bit dp;
      x = 16'(xi); y = 16'(yi); z = 16'(zi);
      for (int i = 0; i < N; i++) begin
         dp = m ? (y < 0) : (z >= 0);
         xs = x >>> i;
         ys = y >>> i;
         if (dp) begin
            x = x - ys; y = y + xs; z = z - 16'(tbl[i]);
         end else begin
            x = x + ys; y = y - xs; z = z + 16'(tbl[i]);
         end
      end
      xo = int'(x); yo = int'(y); zo = int'(z);
   endtask

   function automatic int sx(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   // driver: computes the expectation, pushes it, pulses start
   task automatic launch(input bit m, input int xi, input int yi, input int zi, input string tag);
      int ex, ey, ez;
      model(m, xi, yi, zi, ex, ey, ez);
      q_x.push_back(ex); q_y.push_back(ey); q_z.push_back(ez); q_t.push_back(tag);
      @(negedge clk);
      mode = m; x_in = 16'(xi); y_in = 16'(yi); z_in = 16'(zi); start = 1'b1;
      q_c.push_back(cyc);
      @(negedge clk);
      start = 1'b0;
      last_x = ex; last_y = ey; last_z = ez;
   endtask

   task automatic settle_and_hold(input string tag);
      repeat (N + 4) @(negedge clk);
      chk(sx(x_out) == last_x && sx(y_out) == last_y && sx(z_out) == last_z,
          {tag, " R9 hold x"}, sx(x_out), last_x);
   endtask

   // monitor: pops an expectation on every done pulse
   initial begin
      int c0;
      string t;
      forever begin
         @(negedge clk);
         if (done) begin
            n_done++;
            if (q_t.size() == 0) begin
               chk(0, "R8 unexpected done", 1, 0);
            end else begin
               t = q_t.pop_front();
               c0 = q_c.pop_front();
               chk(sx(x_out) == q_x[0], {t, " x"}, sx(x_out), q_x[0]);
               chk(sx(y_out) == q_y[0], {t, " y"}, sx(y_out), q_y[0]);
               chk(sx(z_out) == q_z[0], {t, " z"}, sx(z_out), q_z[0]);
               chk(cyc - c0 == N + 1, {t, " R7 latency"}, cyc - c0, N + 1);
               void'(q_x.pop_front()); void'(q_y.pop_front()); void'(q_z.pop_front());
               @(negedge clk);
               chk(!done, {t, " R7 single pulse"}, int'(done), 0);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         chk(0, "watchdog", 0, 1);
         summary();
      end
   end

   initial begin
      real r;
      int d0;
      for (int i = 0; i < N; i++)
         tbl[i] = $rtoi($atan(2.0 ** (-i)) * 8192.0 / PI + 0.5);

      repeat (3) @(negedge clk);
      // R10: reset state
      chk(done == 1'b0, "R10 done", int'(done), 0);
      chk(x_out == 0 && y_out == 0 && z_out == 0, "R10 outputs", sx(x_out) | sx(y_out) | sx(z_out), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1, R11: rotate pre-scaled vector by pi/4
      launch(1'b0, 9950, 0, 2048, "R1 rot pi/4");
      settle_and_hold("R1");
      r = 16384.0 * $cos(PI / 4.0);
      chk((sx(x_out) - r) < 8.0 && (r - sx(x_out)) < 8.0, "R11 cos", sx(x_out), $rtoi(r));
      chk((sx(y_out) - r) < 8.0 && (r - sx(y_out)) < 8.0, "R11 sin", sx(y_out), $rtoi(r));

      // R3: z exactly zero takes d=+1
      launch(1'b0, 5000, 3000, 0, "R3 rot z=0");
      settle_and_hold("R3");

      // R5: negative operands with arithmetic shift
      launch(1'b0, -7000, 2000, -3000, "R5 rot negative");
      settle_and_hold("R5");

      // R2, R11: vectoring magnitude and angle
      launch(1'b1, 12000, 9000, 0, "R2 vec");
      settle_and_hold("R2");
      r = 1.6467602581 * 15000.0;
      chk((sx(x_out) - r) < 8.0 && (r - sx(x_out)) < 8.0, "R11 magnitude", sx(x_out), $rtoi(r));
      r = $atan2(9000.0, 12000.0) * 8192.0 / PI;
      chk((sx(z_out) - r) < 8.0 && (r - sx(z_out)) < 8.0, "R11 angle", sx(z_out), $rtoi(r));

      // R4: y exactly zero takes d=-1
      launch(1'b1, 8000, 0, 100, "R4 vec y=0");
      settle_and_hold("R4");

      // R5 / R2: negative y in vectoring
      launch(1'b1, 6000, -10000, 0, "R5 vec negative y");
      settle_and_hold("R5 vec");

      // R6: table values through the accumulated angle
      launch(1'b1, 1000, 1000, 0, "R6 table");
      settle_and_hold("R6");

      // R8: second start during a run is ignored
      d0 = n_done;
      launch(1'b0, 4000, -4000, 1500, "R8 first");
      repeat (3) @(negedge clk);
      mode = 1'b1; x_in = 16'd100; y_in = 16'd200; z_in = 16'd300; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (N + 6) @(negedge clk);
      chk(n_done - d0 == 1, "R8 done count", n_done - d0, 1);
      chk(sx(x_out) == last_x && sx(z_out) == last_z, "R8 result kept", sx(z_out), last_z);

      finished = 1;
      summary();
   end
endmodule